// File: doc/BRIEF.md
# Barrel Shift Execution Unit

This unit executes the register-register shift instructions of a small in-order processor. Each cycle it may receive an instruction word together with two 32-bit register operands: the value to shift and the register that holds the shift amount. It decodes the opcode, the direction bit and the type bit. It then performs a left logical, right logical or right arithmetic shift and returns the result with a valid strobe and the destination register index.

A build-time parameter selects the latency. The one-cycle variant computes the whole shift combinationally and registers the result. The two-cycle variant first shifts by the upper two amount bits and registers that partial value with its decoded controls. A second stage then applies the remaining amount bits. Both variants accept one instruction per cycle and return results in issue order. A second parameter removes the datapath entirely, so that the unit never reports a result.

Instruction bits are given here in little-endian positions of `instr_i`. The opcode is `instr_i[31:26]`, the destination index is `instr_i[25:21]`, the direction bit is `instr_i[10]`, the type bit is `instr_i[9]`, and `instr_i[8:0]` is reserved.

Top module: `bsh_unit`

## Requirements
- R1: An issued instruction produces a result only when `instr_i[31:26]` equals 6'b010001; any other opcode yields no valid result.
- R2: An instruction whose opcode matches but whose reserved field `instr_i[8:0]` is nonzero yields no valid result.
- R3: When `instr_i[10]` is 1 the result is `opa_i` shifted left with zeros entering at the LSB end, regardless of `instr_i[9]`.
- R4: When `instr_i[10]` is 0 and `instr_i[9]` is 0 the result is `opa_i` shifted right with zeros entering at the MSB end.
- R5: When `instr_i[10]` is 0 and `instr_i[9]` is 1 the result is `opa_i` shifted right with copies of `opa_i[31]` entering at the MSB end.
- R6: The shift distance is `opb_i[4:0]`; bits `opb_i[31:5]` do not affect the result.
- R7: A shift distance of zero returns `opa_i` unchanged for all three shift kinds.
- R8: With `TWO_STAGE`=0 the result is valid one clock edge after issue, and with `TWO_STAGE`=1 it is valid two edges after issue. A new instruction may be issued every cycle, and results leave in issue order.
- R9: Each valid result carries `res_rd_o` equal to `instr_i[25:21]` of its instruction.
- R10: Asserting `rst_n` low clears `res_valid_o` at once, and the output stays invalid until a new legal instruction has passed the pipeline.
- R11: With `ENABLE`=0 `res_valid_o` is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset with synchronous release; clears only the valid flags |
| issue_i | input | 1 | An instruction is presented this cycle |
| instr_i | input | 32 | Instruction word |
| opa_i | input | 32 | Value to be shifted |
| opb_i | input | 32 | Shift amount register; only the low five bits are used |
| res_valid_o | output | 1 | Result strobe |
| res_o | output | 32 | Shift result |
| res_rd_o | output | 5 | Destination register index of the result |

## Verification
The assertions assume that `issue_i`, `instr_i`, `opa_i` and `opb_i` hold known values on every clock edge after reset release. They also assume that `issue_i` is low during the first edge after release, so that the delay line in the checker lines up with the pipeline. The bench drives every input to a defined value from time zero and holds `issue_i` low through both the power-on reset and the mid-run reset. It streams instructions back to back, with occasional idle cycles and with illegal encodings mixed in, so that each property is exercised both with and without a valid result in flight.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned RSVD_W    = 9;

  localparam logic [5:0] OPC_SHIFT_RR = 6'b010001;

  // decoded control word travelling with an operation
  typedef struct packed {
    logic                 legal;
    logic                 left;
    logic                 arith;
    logic [REG_IDX_W-1:0] rd;
  } sh_ctrl_t;

endpackage

// File: rtl/bsh_decode.sv
module bsh_decode
  import bsh_pkg::*;
(
  input  logic               issue_i,
  input  logic [INSTR_W-1:0] instr_i,
  output sh_ctrl_t           ctrl_o
);

  logic opc_hit;
  logic rsvd_clear;

  always_comb begin
    opc_hit      = (instr_i[INSTR_W-1 -: 6] == OPC_SHIFT_RR);
    rsvd_clear   = (instr_i[RSVD_W-1:0] == '0);
    ctrl_o.legal = issue_i & opc_hit & rsvd_clear;
    ctrl_o.left  = instr_i[RSVD_W+1];
    // left direction overrides the type selector
    ctrl_o.arith = ~instr_i[RSVD_W+1] & instr_i[RSVD_W];
    ctrl_o.rd    = instr_i[INSTR_W-7 -: REG_IDX_W];
  end

endmodule

// File: rtl/bsh_levels.sv
module bsh_levels #(
  parameter int unsigned W     = 32,
  parameter int unsigned AMT_W = 5,
  parameter int unsigned LO    = 0,
  parameter int unsigned HI    = 4
) (
  input  logic [W-1:0]     din,
  input  logic [AMT_W-1:0] amt,
  input  logic             left,
  input  logic             fill,
  output logic [W-1:0]     dout
);

  logic [W-1:0] lvl [LO:HI+1];

  assign lvl[LO] = din;

  for (genvar k = LO; k <= HI; k++) begin : g_lvl
    localparam int unsigned SH = 1 << k;
    logic [W-1:0] to_left;
    logic [W-1:0] to_right;
    assign to_left    = {lvl[k][W-1-SH:0], {SH{1'b0}}};
    assign to_right   = {{SH{fill}}, lvl[k][W-1:SH]};
    assign lvl[k+1]   = !amt[k] ? lvl[k] : (left ? to_left : to_right);
  end

  assign dout = lvl[HI+1];

endmodule

// File: rtl/bsh_unit.sv
module bsh_unit
  import bsh_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter bit          TWO_STAGE = 1'b0,
  parameter bit          ENABLE    = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_i,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic [XLEN-1:0]      opa_i,
  input  logic [XLEN-1:0]      opb_i,
  output logic                 res_valid_o,
  output logic [XLEN-1:0]      res_o,
  output logic [REG_IDX_W-1:0] res_rd_o
);

  localparam int unsigned AMT_W = $clog2(XLEN);
  localparam int unsigned SPLIT = (AMT_W > 2) ? AMT_W - 2 : 1;

  if (!ENABLE) begin : g_off

    assign res_valid_o = 1'b0;
    assign res_o       = '0;
    assign res_rd_o    = '0;

  end else begin : g_on

    sh_ctrl_t         dec;
    logic [AMT_W-1:0] amount;
    logic             fill_in;

    bsh_decode u_dec (
      .issue_i (issue_i),
      .instr_i (instr_i),
      .ctrl_o  (dec)
    );

    assign amount  = opb_i[AMT_W-1:0];
    assign fill_in = dec.arith & opa_i[XLEN-1];

    if (!TWO_STAGE) begin : g_one

      logic [XLEN-1:0]      shift_d;
      logic                 vld_d, vld_q;
      logic                 load_en;
      logic [XLEN-1:0]      res_q;
      logic [REG_IDX_W-1:0] rd_q;

      bsh_levels #(.W(XLEN), .AMT_W(AMT_W), .LO(0), .HI(AMT_W-1)) u_full (
        .din  (opa_i),
        .amt  (amount),
        .left (dec.left),
        .fill (fill_in),
        .dout (shift_d)
      );

      always_comb begin
        vld_d   = dec.legal;
        load_en = dec.legal;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= vld_d;
      end

      always_ff @(posedge clk) begin
        if (load_en) begin
          res_q <= shift_d;
          rd_q  <= dec.rd;
        end
      end

      assign res_valid_o = vld_q;
      assign res_o       = res_q;
      assign res_rd_o    = rd_q;

    end else begin : g_two

      // stage 1: coarse shift by the upper amount bits
      logic [XLEN-1:0]      coarse_d;
      logic                 s1_vld_d, s1_vld_q, s1_en;
      logic [XLEN-1:0]      s1_data_q;
      logic [AMT_W-1:0]     s1_amt_q;
      logic                 s1_left_q, s1_fill_q;
      logic [REG_IDX_W-1:0] s1_rd_q;

      // stage 2: fine shift by the lower amount bits
      logic [XLEN-1:0]      fine_d;
      logic                 s2_vld_d, s2_vld_q, s2_en;
      logic [XLEN-1:0]      s2_data_q;
      logic [REG_IDX_W-1:0] s2_rd_q;

      bsh_levels #(.W(XLEN), .AMT_W(AMT_W), .LO(SPLIT), .HI(AMT_W-1)) u_coarse (
        .din  (opa_i),
        .amt  (amount),
        .left (dec.left),
        .fill (fill_in),
        .dout (coarse_d)
      );

      always_comb begin
        s1_vld_d = dec.legal;
        s1_en    = dec.legal;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s1_vld_q <= 1'b0;
        else        s1_vld_q <= s1_vld_d;
      end

      always_ff @(posedge clk) begin
        if (s1_en) begin
          s1_data_q <= coarse_d;
          s1_amt_q  <= amount;
          s1_left_q <= dec.left;
          s1_fill_q <= fill_in;
          s1_rd_q   <= dec.rd;
        end
      end

      bsh_levels #(.W(XLEN), .AMT_W(AMT_W), .LO(0), .HI(SPLIT-1)) u_fine (
        .din  (s1_data_q),
        .amt  (s1_amt_q),
        .left (s1_left_q),
        .fill (s1_fill_q),
        .dout (fine_d)
      );

      always_comb begin
        s2_vld_d = s1_vld_q;
        s2_en    = s1_vld_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s2_vld_q <= 1'b0;
        else        s2_vld_q <= s2_vld_d;
      end

      always_ff @(posedge clk) begin
        if (s2_en) begin
          s2_data_q <= fine_d;
          s2_rd_q   <= s1_rd_q;
        end
      end

      assign res_valid_o = s2_vld_q;
      assign res_o       = s2_data_q;
      assign res_rd_o    = s2_rd_q;

    end
  end

endmodule

module bsh_chk
  import bsh_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter bit          TWO_STAGE = 1'b0,
  parameter bit          ENABLE    = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 issue_i,
  input logic [INSTR_W-1:0]   instr_i,
  input logic [XLEN-1:0]      opa_i,
  input logic [XLEN-1:0]      opb_i,
  input logic                 res_valid_o,
  input logic [XLEN-1:0]      res_o,
  input logic [REG_IDX_W-1:0] res_rd_o
);

  localparam int unsigned AMT_W = $clog2(XLEN);
  localparam int unsigned LAT   = TWO_STAGE ? 2 : 1;

  logic [1:0] warm;
  logic       warm_ok;
  logic       in_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assign warm_ok = (warm >= 2'(LAT));
  assign in_ok   = issue_i && (instr_i[31:26] == 6'b010001) && (instr_i[8:0] == 9'd0);

  // two-deep delay line of the issued operation as seen at the ports
  logic                 l1, l2;
  logic [4:0]           rd1, rd2;
  logic [XLEN-1:0]      a1, a2;
  logic [AMT_W-1:0]     n1, n2;
  logic                 lf1, lf2, ar1, ar2;

  always_ff @(posedge clk) begin
    l1 <= in_ok;          l2 <= l1;
    rd1 <= instr_i[25:21]; rd2 <= rd1;
    a1 <= opa_i;          a2 <= a1;
    n1 <= opb_i[AMT_W-1:0]; n2 <= n1;
    lf1 <= instr_i[10];   lf2 <= lf1;
    ar1 <= instr_i[9];    ar2 <= ar1;
  end

  logic             e_legal, e_left, e_arith;
  logic [4:0]       e_rd;
  logic [XLEN-1:0]  e_opa, low_mask;
  logic [AMT_W-1:0] e_amt;

  assign e_legal  = (LAT == 1) ? l1  : l2;
  assign e_rd     = (LAT == 1) ? rd1 : rd2;
  assign e_opa    = (LAT == 1) ? a1  : a2;
  assign e_amt    = (LAT == 1) ? n1  : n2;
  assign e_left   = (LAT == 1) ? lf1 : lf2;
  assign e_arith  = (LAT == 1) ? ar1 : ar2;
  assign low_mask = (XLEN'(1) << e_amt) - XLEN'(1);

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd0) |-> !res_valid_o);

  if (!ENABLE) begin : g_off_chk
    // R11
    never_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid_o);
  end else begin : g_on_chk
    // R8 (also R1, R2)
    valid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      warm_ok |-> (res_valid_o == e_legal));
    // R9
    rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_ok && res_valid_o) |-> (res_rd_o == e_rd));
    // R7
    zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_ok && res_valid_o && e_amt == '0) |-> (res_o == e_opa));
    // R3
    left_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_ok && res_valid_o && e_left) |-> ((res_o & low_mask) == '0));
    // R5
    sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_ok && res_valid_o && !e_left && e_arith && e_opa[XLEN-1]) |-> res_o[XLEN-1]);
    // R4
    logic_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_ok && res_valid_o && !e_left && !e_arith && e_amt != '0) |-> !res_o[XLEN-1]);
  end

endmodule

bind bsh_unit bsh_chk #(.XLEN(XLEN), .TWO_STAGE(TWO_STAGE), .ENABLE(ENABLE)) u_chk (.*);

// File: tb/bsh_unit_tb.sv
module bsh_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;

  logic        v2, v1, v0;
  logic [31:0] r2, r1, r0;
  logic [4:0]  d2, d1, d0;

  always #10 clk = ~clk;

  bsh_unit #(.XLEN(32), .TWO_STAGE(1'b1), .ENABLE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .instr_i(instr), .opa_i(opa), .opb_i(opb),
    .res_valid_o(v2), .res_o(r2), .res_rd_o(d2));

  bsh_unit #(.XLEN(32), .TWO_STAGE(1'b0), .ENABLE(1'b1)) u_dut1 (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .instr_i(instr), .opa_i(opa), .opb_i(opb),
    .res_valid_o(v1), .res_o(r1), .res_rd_o(d1));

  bsh_unit #(.XLEN(32), .TWO_STAGE(1'b0), .ENABLE(1'b0)) u_off (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .instr_i(instr), .opa_i(opa), .opb_i(opb),
    .res_valid_o(v0), .res_o(r0), .res_rd_o(d0));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [31:0] data;
    logic [4:0]  rd;
    int          c;
    string       tag;
  } exp_t;

  exp_t q2[$];
  exp_t q1[$];
  exp_t e2, e1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // arithmetic reference: multiply / divide by a power of two
  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input bit s, input bit t);
    longint unsigned p = 1;
    longint unsigned prod;
    for (int i = 0; i < int'(b % 32); i++) p = p * 2;
    if (s) begin
      prod = longint'(a) * p;
      return prod[31:0];
    end else if (t && a[31]) begin
      return ~((~a) / p[31:0]);
    end
    return a / p[31:0];
  endfunction

  // monitors sample at the falling edge, away from register updates
  always @(negedge clk) begin
    if (rst_n) begin
      if (v2) begin
        if (q2.size() == 0) chk(1'b0, "R1/R2 two-stage unexpected valid", r2, 32'h0);
        else begin
          e2 = q2.pop_front();
          chk(r2 == e2.data, {e2.tag, " two-stage data"}, r2, e2.data);
          chk(d2 == e2.rd, "R9 two-stage rd", 32'(d2), 32'(e2.rd));
          chk(cyc - e2.c == 2, "R8 two-stage latency", 32'(cyc - e2.c), 32'd2);
        end
      end
      if (v1) begin
        if (q1.size() == 0) chk(1'b0, "R1/R2 one-stage unexpected valid", r1, 32'h0);
        else begin
          e1 = q1.pop_front();
          chk(r1 == e1.data, {e1.tag, " one-stage data"}, r1, e1.data);
          chk(d1 == e1.rd, "R9 one-stage rd", 32'(d1), 32'(e1.rd));
          chk(cyc - e1.c == 1, "R8 one-stage latency", 32'(cyc - e1.c), 32'd1);
        end
      end
      chk(!v0, "R11 disabled unit valid", 32'(v0), 32'd0);
    end
  end

  task automatic send(input logic v, input logic [31:0] ins, input logic [31:0] a,
                      input logic [31:0] b, input string tag);
    exp_t e;
    @(negedge clk);
    issue = v; instr = ins; opa = a; opb = b;
    if (v && ins[31:26] == 6'b010001 && ins[8:0] == 9'd0) begin
      e.data = model(a, b, ins[10], ins[9]);
      e.rd   = ins[25:21];
      e.c    = cyc;
      e.tag  = tag;
      q2.push_back(e);
      q1.push_back(e);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] rd, input bit s, input bit t);
    return {6'b010001, rd, 5'd3, 5'd7, s, t, 9'd0};
  endfunction

  function automatic logic [31:0] pat(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h0000_0001;
      4: return 32'h7FFF_FFFF;
      5: return 32'hA5A5_A5A5;
      6: return 32'h1234_5678;
      default: return 32'hF0F0_000F;
    endcase
  endfunction

  task automatic run_all();
    int n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!v2, "R10 reset valid two-stage", 32'(v2), 32'd0);
    chk(!v1, "R10 reset valid one-stage", 32'(v1), 32'd0);
    chk(!v0, "R10 reset valid disabled", 32'(v0), 32'd0);
    rst_n = 1'b1;
    send(1'b0, 32'h0, 32'h0, 32'h0, "idle");

    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < 8; p++) begin
        for (int a = 0; a < 32; a++) begin
          logic s, t;
          logic [31:0] b;
          string tag;
          s = (k == 0) || (k == 3);
          t = (k == 2) || (k == 3);
          b = 32'(a) | ((32'(p) * 32'h9E37_79B9 + 32'(a) * 32'h0100_0193) & ~32'h1F);
          if (s)      tag = "R3/R6";
          else if (t) tag = "R5/R6";
          else        tag = "R4/R6";
          if (a == 0) tag = {tag, "/R7"};
          send(1'b1, mk(5'((n * 7) % 32), s, t), pat(p), b, tag);
          n++;
          if (n % 11 == 0)
            send(1'b1, {6'b010001, 5'd9, 10'd0, s, t, 9'(1 << (n % 9))}, pat(p), b, "R2");
          if (n % 13 == 0)
            send(1'b1, {6'(6'b010001 ^ (6'd1 << (n % 6))), 5'd10, 10'd0, s, t, 9'd0}, pat(p), b, "R1");
          if (n % 5 == 0)
            send(1'b0, 32'h0, 32'h0, 32'h0, "idle");
        end
      end
    end

    // reset with operations in flight
    send(1'b1, mk(5'd17, 1'b0, 1'b1), 32'h8000_0010, 32'd4, "R5");
    send(1'b0, 32'h0, 32'h0, 32'h0, "idle");
    @(posedge clk);
    #2 rst_n = 1'b0;
    q2.delete();
    q1.delete();
    @(negedge clk);
    chk(!v2, "R10 mid-run reset two-stage", 32'(v2), 32'd0);
    chk(!v1, "R10 mid-run reset one-stage", 32'(v1), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    send(1'b0, 32'h0, 32'h0, 32'h0, "idle");
    send(1'b0, 32'h0, 32'h0, 32'h0, "idle");
    chk(!v2, "R10 after reset two-stage", 32'(v2), 32'd0);
    chk(!v1, "R10 after reset one-stage", 32'(v1), 32'd0);
    send(1'b1, mk(5'd31, 1'b1, 1'b0), 32'h0000_0003, 32'hFFFF_FFE1, "R3/R6");

    repeat (4) send(1'b0, 32'h0, 32'h0, 32'h0, "idle");
    chk(q2.size() == 0, "R8 two-stage results outstanding", 32'(q2.size()), 32'd0);
    chk(q1.size() == 0, "R8 one-stage results outstanding", 32'(q1.size()), 32'd0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule